// File: doc/BRIEF.md
# Region Block Eviction Sequencer

This block takes a whole memory region out of a peer cache, one cache block at a time. A start command supplies the region base, the probe kind (invalidate or downgrade), an optional demand request with its block address, and a bit vector that marks which block slots of the region hold valid data. The sequencer then sends one probe per valid slot to the peer cache and counts the acknowledgements it still expects.

When a demand request comes with the command, that block is probed first, on its own, and carries a demand marker. The walk then skips the demand block so that it is never probed twice. The demand block is still counted: if the vector does not mark it valid, one extra acknowledgement is expected for it.

Completion needs two things: the walk has passed the last slot, and the outstanding count is zero. These may happen in either order. Completion is a one-cycle pulse that also carries the OR of the dirty flags from all accepted acknowledgements. The sequencer then returns to idle and accepts the next command.

Top module: `region_evict_seq`

## Requirements
- R1: A start command is taken only when `start_ready` is high, which is only while idle. `start_valid` during a walk has no effect on the probes issued or on the count.
- R2: The stored region base is `start_base` with its low `BLK_OFF_W+log2(BLKS)` bits (12 by default) cleared. A walk probe for slot k carries the address base + k·2^`BLK_OFF_W` (k·64 by default).
- R3: The walk visits slots 0 to `BLKS-1` in ascending order. It issues a probe only for a slot whose vector bit is 1 and which is not the demand block. Each walk probe has `probe_demand`=0 and `probe_kind` equal to the start kind (0 = invalidate, 1 = downgrade).
- R4: When `start_demand`=1, the first probe issued carries `start_demand_addr` unchanged, with `probe_demand`=1, before any walk probe.
- R5: The expected acknowledgement count is the population count of the valid vector, plus one when a demand is present and its block (address bits `BLK_OFF_W` upward, `log2(BLKS)` wide) is not marked valid.
- R6: An acknowledgement lowers the count by one only while busy, only when the count is non-zero, and only for a block index not already acknowledged in this walk. A repeated index is ignored.
- R7: With `probe_ready` held high, each slot takes 1+`STEP_GAP` cycles. Slot k is evaluated in cycle (demand?1:0)+k·(1+`STEP_GAP`) after the accepting edge. The walk finishes one cycle after the last slot is evaluated.
- R8: While `probe_valid` is high and `probe_ready` is low, the probe stays valid and its address, kind and demand flag stay unchanged, and the walk does not advance.
- R9: `done_pulse` is high for exactly one cycle, in the first cycle in which the walk is finished and the count is zero, whichever of the two came last. The block is idle in the following cycle.
- R10: `done_dirty`, read while `done_pulse` is high, is the OR of the dirty flags of all acknowledgements accepted during the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start command present |
| start_ready | output | 1 | Sequencer idle, command will be taken |
| start_base | input | ADDR_W | Any address inside the region |
| start_kind | input | 1 | 0 invalidate, 1 downgrade |
| start_demand | input | 1 | A demand request accompanies the command |
| start_demand_addr | input | ADDR_W | Block address of the demand request |
| start_valid_map | input | BLKS | Valid flag per block slot |
| probe_valid | output | 1 | Probe request present |
| probe_ready | input | 1 | Peer accepts the probe |
| probe_addr | output | ADDR_W | Block address to probe |
| probe_kind | output | 1 | Probe kind, copied from the command |
| probe_demand | output | 1 | Probe is the demand probe |
| ack_valid | input | 1 | Acknowledgement present |
| ack_idx | input | log2(BLKS) | Block index within the region being acknowledged |
| ack_dirty | input | 1 | Acknowledged block was dirty |
| done_pulse | output | 1 | One-cycle completion |
| done_dirty | output | 1 | Accumulated dirty status |

## Verification
With no demand and no stall, an empty region completes exactly 127 cycles after the accepting edge, and 128 cycles when a demand probe goes first. Probe handshakes on valid slots j and k fall 2·(k−j) cycles apart, and the bench compares these recorded edge numbers directly. All inputs change on the falling edge and all outputs are read there, so every result is read in the cycle after the rising edge that produced it. A done pulse that comes too early or twice is caught by a counter of pulses, which is read after the walk has had time to finish.

// File: rtl/region_evict_seq.sv
module region_evict_seq #(
  parameter int ADDR_W    = 32,
  parameter int BLK_OFF_W = 6,
  parameter int BLKS      = 64,
  parameter int STEP_GAP  = 1,
  localparam int IDX_W    = $clog2(BLKS),
  localparam int CNT_W    = $clog2(BLKS + 2),
  localparam int GAP_W    = $clog2(STEP_GAP + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] start_base,
  input  logic              start_kind,
  input  logic              start_demand,
  input  logic [ADDR_W-1:0] start_demand_addr,
  input  logic [BLKS-1:0]   start_valid_map,
  output logic              probe_valid,
  input  logic              probe_ready,
  output logic [ADDR_W-1:0] probe_addr,
  output logic              probe_kind,
  output logic              probe_demand,
  input  logic              ack_valid,
  input  logic [IDX_W-1:0]  ack_idx,
  input  logic              ack_dirty,
  output logic              done_pulse,
  output logic              done_dirty
);

  localparam logic [ADDR_W-1:0] REG_MASK = (ADDR_W'(1) << (BLK_OFF_W + IDX_W)) - ADDR_W'(1);
  localparam logic [IDX_W-1:0]  LAST     = IDX_W'(BLKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_DEM, S_WALK, S_FIN} st_t;

  st_t               st;
  logic [ADDR_W-1:0] base, dem_addr;
  logic              kind, dem, dirty;
  logic [BLKS-1:0]   map, acked;
  logic [IDX_W-1:0]  idx;
  logic [GAP_W-1:0]  gap;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [CNT_W-1:0] pop_of(input logic [BLKS-1:0] v);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < BLKS; i++) s = s + CNT_W'(v[i]);
    return s;
  endfunction

  wire [IDX_W-1:0] dem_idx    = dem_addr[BLK_OFF_W +: IDX_W];
  wire [IDX_W-1:0] in_dem_idx = start_demand_addr[BLK_OFF_W +: IDX_W];
  wire             slot_need  = map[idx] && !(dem && idx == dem_idx);
  wire             slot_live  = (st == S_WALK) && (gap == '0);
  wire             ack_take   = (st != S_IDLE) && ack_valid && !acked[ack_idx] && (cnt != '0);

  assign start_ready  = (st == S_IDLE);
  assign probe_valid  = (st == S_DEM) || (slot_live && slot_need);
  assign probe_demand = (st == S_DEM);
  assign probe_kind   = kind;
  assign probe_addr   = (st == S_DEM) ? dem_addr
                                      : (base | (ADDR_W'(idx) << BLK_OFF_W));
  assign done_pulse   = (st == S_FIN) && (cnt == '0);
  assign done_dirty   = dirty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      base     <= '0;
      dem_addr <= '0;
      kind     <= 1'b0;
      dem      <= 1'b0;
      map      <= '0;
      acked    <= '0;
      idx      <= '0;
      gap      <= '0;
      cnt      <= '0;
      dirty    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_valid) begin
          st       <= start_demand ? S_DEM : S_WALK;
          base     <= start_base & ~REG_MASK;
          dem_addr <= start_demand_addr;
          kind     <= start_kind;
          dem      <= start_demand;
          map      <= start_valid_map;
          acked    <= '0;
          idx      <= '0;
          gap      <= '0;
          dirty    <= 1'b0;
          cnt      <= pop_of(start_valid_map)
                    + CNT_W'(start_demand && !start_valid_map[in_dem_idx]);
        end
        S_DEM: if (probe_ready) st <= S_WALK;
        S_WALK: begin
          if (gap != '0) begin
            gap <= gap - GAP_W'(1);
          end else if (!slot_need || probe_ready) begin
            if (idx == LAST) begin
              st <= S_FIN;
            end else begin
              idx <= idx + IDX_W'(1);
              gap <= GAP_W'(STEP_GAP);
            end
          end
        end
        S_FIN: if (cnt == '0) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (ack_take) begin
        cnt            <= cnt - CNT_W'(1);
        acked[ack_idx] <= 1'b1;
        dirty          <= dirty | ack_dirty;
      end
    end
  end

endmodule

// File: rtl/region_evict_seq_chk.sv
module region_evict_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic              probe_valid,
  input logic              probe_ready,
  input logic [ADDR_W-1:0] probe_addr,
  input logic              probe_kind,
  input logic              probe_demand,
  input logic              done_pulse
);

  AST_START_TAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready |=> !start_ready); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !probe_valid && !done_pulse); // R1

  AST_PROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid && !probe_ready |=> probe_valid && $stable(probe_addr)
      && $stable(probe_kind) && $stable(probe_demand)); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse && start_ready); // R9

  AST_DONE_NOT_WITH_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !probe_valid); // R9

endmodule

bind region_evict_seq region_evict_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .probe_valid (probe_valid),
  .probe_ready (probe_ready),
  .probe_addr  (probe_addr),
  .probe_kind  (probe_kind),
  .probe_demand(probe_demand),
  .done_pulse  (done_pulse)
);

// File: tb/region_evict_seq_tb_top.sv
module region_evict_seq_tb_top;
  localparam int AW = 32;
  localparam int NB = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic [AW-1:0] start_base = '0;
  logic          start_kind = 1'b0;
  logic          start_demand = 1'b0;
  logic [AW-1:0] start_demand_addr = '0;
  logic [NB-1:0] start_valid_map = '0;
  logic          probe_valid;
  logic          probe_ready = 1'b1;
  logic [AW-1:0] probe_addr;
  logic          probe_kind;
  logic          probe_demand;
  logic          ack_valid = 1'b0;
  logic [5:0]    ack_idx = '0;
  logic          ack_dirty = 1'b0;
  logic          done_pulse;
  logic          done_dirty;

  region_evict_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_base(start_base), .start_kind(start_kind),
    .start_demand(start_demand), .start_demand_addr(start_demand_addr),
    .start_valid_map(start_valid_map),
    .probe_valid(probe_valid), .probe_ready(probe_ready),
    .probe_addr(probe_addr), .probe_kind(probe_kind), .probe_demand(probe_demand),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .ack_dirty(ack_dirty),
    .done_pulse(done_pulse), .done_dirty(done_dirty)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  longint cyc = 0;
  longint t0 = 0;
  int     pn = 0;
  int     dn = 0;
  logic [AW-1:0] pa [0:127];
  logic          pk [0:127];
  logic          pd [0:127];
  longint        pt [0:127];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && probe_valid && probe_ready && pn < 128) begin
      pa[pn] <= probe_addr; pk[pn] <= probe_kind; pd[pn] <= probe_demand; pt[pn] <= cyc;
      pn <= pn + 1;
    end
    if (rst_n && done_pulse) dn <= dn + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_cmd(input logic [AW-1:0] b, input logic k, input logic d,
                           input logic [AW-1:0] da, input logic [NB-1:0] m);
    @(negedge clk);
    pn = 0; dn = 0;
    start_base = b; start_kind = k; start_demand = d; start_demand_addr = da;
    start_valid_map = m; start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    t0 = cyc;
  endtask

  task automatic ack(input int i, input logic dty);
    @(negedge clk);
    ack_valid = 1'b1; ack_idx = 6'(i); ack_dirty = dty;
    @(negedge clk);
    ack_valid = 1'b0; ack_dirty = 1'b0;
  endtask

  task automatic wait_rel(input longint n);
    while (cyc - t0 < n) @(negedge clk);
  endtask

  task automatic wait_done(output longint rel, output logic dty);
    int guard = 0;
    while (!done_pulse && guard < 1000) begin @(negedge clk); guard++; end
    rel = cyc - t0; dty = done_dirty;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(start_ready === 1'b1, "R1 ready after reset", longint'(start_ready), 1);
    chk(probe_valid === 1'b0 && done_pulse === 1'b0, "R9 quiet after reset",
        longint'({probe_valid, done_pulse}), 0);
  endtask

  task automatic t_empty;
    longint r; logic dy;
    start_cmd(32'h0000_8000, 1'b0, 1'b0, '0, '0);
    wait_done(r, dy);
    chk(r == 127, "R7 empty region done cycle", r, 127);
    chk(pn == 0, "R3 no probes for empty map", pn, 0);
    chk(dy == 1'b0, "R10 clean when no acks", longint'(dy), 0);
    chk(start_ready === 1'b1 && dn == 1, "R9 single pulse then idle", dn, 1);
  endtask

  task automatic t_basic;
    longint r; logic dy;
    logic [NB-1:0] m;
    m = '0; m[0] = 1'b1; m[5] = 1'b1; m[63] = 1'b1;
    start_cmd(32'h0004_0000, 1'b0, 1'b0, '0, m);
    wait_rel(135);
    chk(pn == 3, "R3 probe count", pn, 3);
    chk(pa[0] == 32'h0004_0000 && pa[1] == 32'h0004_0140 && pa[2] == 32'h0004_0FC0,
        "R2 slot addresses", longint'(pa[1]), 32'h0004_0140);
    chk(pk[0] == 1'b0 && pd[0] == 1'b0 && pd[2] == 1'b0, "R3 kind and flag", longint'(pd[0]), 0);
    chk(pt[1] - pt[0] == 10 && pt[2] - pt[1] == 116, "R7 slot spacing", pt[2] - pt[1], 116);
    chk(dn == 0, "R9 waits for acks", dn, 0);
    ack(5, 1'b1); ack(0, 1'b0);
    chk(dn == 0, "R5 count of three not yet zero", dn, 0);
    ack(63, 1'b0);
    wait_done(r, dy);
    chk(dn == 1, "R9 done after last ack", dn, 1);
    chk(dy == 1'b1, "R10 dirty OR", longint'(dy), 1);
  endtask

  task automatic t_demand_valid;
    longint r; logic dy;
    logic [NB-1:0] m;
    m = '0; m[5] = 1'b1; m[9] = 1'b1;
    start_cmd(32'h1234_5ABC, 1'b1, 1'b1, 32'h1234_5140, m);
    wait_rel(135);
    chk(pn == 2, "R3 demand block skipped", pn, 2);
    chk(pa[0] == 32'h1234_5140 && pd[0] == 1'b1, "R4 demand probe first", longint'(pa[0]), 32'h1234_5140);
    chk(pa[1] == 32'h1234_5240 && pd[1] == 1'b0 && pk[1] == 1'b1, "R2 masked base",
        longint'(pa[1]), 32'h1234_5240);
    ack(5, 1'b0); ack(5, 1'b1);
    wait_rel(145);
    chk(dn == 0, "R6 repeated index ignored", dn, 0);
    ack(9, 1'b0);
    wait_done(r, dy);
    chk(dn == 1, "R5 two acks expected", dn, 1);
    chk(dy == 1'b0, "R10 ignored ack adds no dirt", longint'(dy), 0);
  endtask

  task automatic t_demand_invalid;
    longint r; logic dy;
    logic [NB-1:0] m;
    m = '0; m[2] = 1'b1;
    start_cmd(32'h0010_0000, 1'b0, 1'b1, 32'h0010_01C0, m);
    wait_rel(135);
    ack(2, 1'b0);
    wait_rel(140);
    chk(dn == 0, "R5 extra ack for invalid demand", dn, 0);
    ack(7, 1'b1);
    wait_done(r, dy);
    chk(dn == 1 && dy == 1'b1, "R5 done after demand ack", dn, 1);
  endtask

  task automatic t_early;
    longint r; logic dy;
    start_cmd(32'h0020_0000, 1'b0, 1'b1, 32'h0020_0280, '0);
    ack(10, 1'b0);
    ack(11, 1'b1);
    wait_done(r, dy);
    chk(r == 128, "R9 acks first, done at walk end", r, 128);
    chk(dy == 1'b0, "R6 ack with zero count ignored", longint'(dy), 0);
  endtask

  task automatic t_busy;
    longint r; logic dy;
    logic [NB-1:0] m;
    m = '0; m[1] = 1'b1;
    start_cmd(32'h0030_0000, 1'b0, 1'b0, '0, m);
    @(negedge clk);
    chk(start_ready === 1'b0, "R1 not ready while busy", longint'(start_ready), 0);
    start_valid_map = '1; start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    wait_rel(135);
    chk(pn == 1, "R1 start during walk ignored", pn, 1);
    ack(1, 1'b0);
    wait_done(r, dy);
    chk(dn == 1, "R1 original count kept", dn, 1);
  endtask

  task automatic t_stall;
    longint r; logic dy;
    logic [NB-1:0] m;
    logic [AW-1:0] held;
    m = '0; m[4] = 1'b1; m[6] = 1'b1;
    probe_ready = 1'b0;
    start_cmd(32'h0040_0000, 1'b0, 1'b0, '0, m);
    while (!probe_valid) @(negedge clk);
    held = probe_addr;
    repeat (5) @(negedge clk);
    chk(probe_valid === 1'b1 && probe_addr == held && held == 32'h0040_0100,
        "R8 probe held under stall", longint'(probe_addr), 32'h0040_0100);
    probe_ready = 1'b1;
    wait_rel(140);
    chk(pn == 2 && pa[1] == 32'h0040_0180, "R8 walk resumes", pn, 2);
    ack(4, 1'b0); ack(6, 1'b0);
    wait_done(r, dy);
    chk(dn == 1, "R9 done after stalled walk", dn, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_basic();
    t_demand_valid();
    t_demand_invalid();
    t_early();
    t_busy();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule